// File: doc/BRIEF.md
# Compare Timer Bank

A bank of four independent 16-bit up-counters. Each has a count, a mode and a compare register, and the first two also have a hold register. While a timer is enabled, it advances by one on every clock edge where the shared `tick` enable is high. When an advance lands on the compare value, the timer sends a single-cycle request on its own interrupt line. Downstream, timer i is wired to interrupt-controller input 9+i. That controller keeps the level until software clears it. A mode bit chooses whether the counter drops to zero at a match or runs on.

Timer 0 is free-running and keeps generating matches. Timers 1 to 3 are one-shot: the match that fires them also clears their enable bit, so they stop until software re-arms them. Software reads and writes every register through a single-cycle synchronous port. Read data is combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: Address bits [7:6] select the timer and bits [5:4] select its register: 0 count, 1 mode, 2 compare, 3 hold. Bits [3:0] are ignored. A write with `reg_wr` high is visible on `reg_rdata` from the next cycle. `reg_rdata` follows `reg_addr` without a clock.
- R2: A timer whose mode bit 7 is set advances its count by one on each clock edge where `tick` is high. With bit 7 clear, or `tick` low, the count does not change.
- R3: When an advance produces a value equal to the timer's compare register, `irq[i]` is high for exactly the one cycle after that edge.
- R4: With mode bit 6 set, the count becomes 0 at a match instead of the compare value.
- R5: With mode bit 6 clear, the count holds the compare value at a match and keeps advancing. It wraps from 0xFFFF to 0 without a request unless compare is 0.
- R6: Timer 0 stays enabled after a match. Timers 1 to 3 clear mode bit 7 in the same edge as their match and stop counting.
- R7: Timers 0 and 1 keep a 16-bit hold value that software can read and write. The hold address of timers 2 and 3 reads 0 and ignores writes.
- R8: A software write to a count register replaces the count on the next edge and wins over a tick in that cycle. It never raises a request, even when it equals compare.
- R9: After reset every register reads 0 and `irq` is 0. The mode register stores 8 bits, and its upper read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable shared by all timers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 4 | One-cycle match requests, bit i from timer i |

## Verification
The timers are first driven with ticks while disabled, to separate gating from counting. Timer 0 is then run past its compare value without zero-return and again with it. The difference in the number of requests and in the final count separates the run-on path from the reload path. Timers 1 and 2 are run as one-shots well past their match, which exposes any extra request or missed enable clear. Timer 3 is preloaded near the top of the range to exercise the wrap. A count write that lands during a tick, and equals compare, shows whether software or the tick wins and whether a write can fire a request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int CNT_W  = 16;
    parameter int MODE_W = 8;
    parameter int EN_BIT = 7;
    parameter int ZR_BIT = 6;

    typedef enum logic [1:0] {
        SEL_CNT  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_HOLD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  hold;
        logic [MODE_W-1:0] mode;
        logic              irq;
    } chan_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter bit HAS_HOLD = 1'b1,
    parameter bit ONE_SHOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  hold_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              irq_o
);
    chan_t ch_d, ch_q;
    logic [CNT_W-1:0] inc;
    logic             step;
    logic             cnt_wr;
    logic             mode_wr;

    assign cnt_wr  = wr_i && (sel_i == SEL_CNT);
    assign mode_wr = wr_i && (sel_i == SEL_MODE);

    always_comb begin
        ch_d     = ch_q;
        ch_d.irq = 1'b0;
        inc      = ch_q.cnt + CNT_W'(1);
        step     = ch_q.mode[EN_BIT] && tick_i;

        if (step) begin
            ch_d.cnt = inc;
            if (inc == ch_q.cmp) begin
                ch_d.irq = 1'b1;
                if (ch_q.mode[ZR_BIT]) ch_d.cnt = '0;
                if (ONE_SHOT)          ch_d.mode[EN_BIT] = 1'b0;
            end
        end

        if (wr_i) begin
            unique case (sel_i)
                SEL_CNT: begin
                    ch_d.cnt = wdata_i;
                    ch_d.irq = 1'b0;
                end
                SEL_MODE: ch_d.mode = wdata_i[MODE_W-1:0];
                SEL_CMP:  ch_d.cmp  = wdata_i;
                SEL_HOLD: if (HAS_HOLD) ch_d.hold = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign cnt_o  = ch_q.cnt;
    assign cmp_o  = ch_q.cmp;
    assign hold_o = ch_q.hold;
    assign mode_o = ch_q.mode;
    assign irq_o  = ch_q.irq;

    // R2: an enabled tick without a match or count write adds exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.mode[EN_BIT] && tick_i && !cnt_wr && (inc != ch_q.cmp))
        |=> (ch_q.cnt == $past(ch_q.cnt) + CNT_W'(1)));

    // R2: disabled timer holds its count unless software writes it
    a_r2_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_q.mode[EN_BIT] && !cnt_wr) |=> (ch_q.cnt == $past(ch_q.cnt)));

    // R3: a request is only ever produced by a ticking edge
    a_r3_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ch_q.irq |-> $past(tick_i));

    // R4: with zero-return the count sits at zero after a request
    a_r4_zero_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.irq && $past(ch_q.mode[ZR_BIT])) |-> (ch_q.cnt == '0));

    // R5: without zero-return the count equals the old compare value
    a_r5_run_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.irq && !$past(ch_q.mode[ZR_BIT])) |-> (ch_q.cnt == $past(ch_q.cmp)));

    // R8: a count write lands as written and fires nothing
    a_r8_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (ch_q.cnt == $past(wdata_i)) && !ch_q.irq);

    generate
        if (ONE_SHOT) begin : g_oneshot_chk
            // R6: one-shot timers are disarmed by their match
            a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_q.irq && !$past(mode_wr)) |-> !ch_q.mode[EN_BIT]);
        end else begin : g_free_chk
            // R6: the free-running timer stays armed after its match
            a_r6_rearm: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_q.irq && !$past(mode_wr)) |-> ch_q.mode[EN_BIT]);
        end
    endgenerate
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4,
    localparam int IDX_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  reg_sel_e          sel_i,
    input  logic [CNT_W-1:0]  cnt_i  [N_TMR],
    input  logic [CNT_W-1:0]  cmp_i  [N_TMR],
    input  logic [CNT_W-1:0]  hold_i [N_TMR],
    input  logic [MODE_W-1:0] mode_i [N_TMR],
    output logic [CNT_W-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (int'(idx_i) < N_TMR) begin
            unique case (sel_i)
                SEL_CNT:  rdata_o = cnt_i[idx_i];
                SEL_MODE: rdata_o = {{(CNT_W-MODE_W){1'b0}}, mode_i[idx_i]};
                SEL_CMP:  rdata_o = cmp_i[idx_i];
                SEL_HOLD: rdata_o = hold_i[idx_i];
                default:  rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TMR  = 4,
    parameter int N_HOLD = 2,
    parameter int ADDR_W = 8,
    localparam int IDX_W   = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int SEL_LSB = 4,
    localparam int IDX_LSB = SEL_LSB + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [N_TMR-1:0]  irq
);
    logic [IDX_W-1:0]  idx;
    reg_sel_e          sel;
    logic [CNT_W-1:0]  cnt_a  [N_TMR];
    logic [CNT_W-1:0]  cmp_a  [N_TMR];
    logic [CNT_W-1:0]  hold_a [N_TMR];
    logic [MODE_W-1:0] mode_a [N_TMR];

    assign idx = reg_addr[IDX_LSB +: IDX_W];
    assign sel = reg_sel_e'(reg_addr[SEL_LSB +: 2]);

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            tmr_channel #(
                .HAS_HOLD (i < N_HOLD),
                .ONE_SHOT (i != 0)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (tick),
                .wr_i    (reg_wr && (int'(idx) == i)),
                .sel_i   (sel),
                .wdata_i (reg_wdata),
                .cnt_o   (cnt_a[i]),
                .cmp_o   (cmp_a[i]),
                .hold_o  (hold_a[i]),
                .mode_o  (mode_a[i]),
                .irq_o   (irq[i])
            );
        end
    endgenerate

    tmr_rdmux #(.N_TMR(N_TMR)) u_rdmux (
        .idx_i   (idx),
        .sel_i   (sel),
        .cnt_i   (cnt_a),
        .cmp_i   (cmp_a),
        .hold_i  (hold_a),
        .mode_i  (mode_a),
        .rdata_o (reg_rdata)
    );

    // R7: hold address of a timer without hold storage always reads zero
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_HOLD) && (int'(idx) >= N_HOLD)) |-> (reg_rdata == '0));

    // R9: mode reads never carry bits above the stored mode width
    a_r9_mode_width: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MODE) |-> (reg_rdata[CNT_W-1:MODE_W] == '0));
endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad   = 0;
    int hits  [4];
    int first [4];

    always #2 clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [1:0] CNT = 2'd0, MODE = 2'd1, CMP = 2'd2, HOLD = 2'd3;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int t, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = {t[1:0], s, 4'h0};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int t, input logic [1:0] s, output logic [15:0] v);
        reg_addr = {t[1:0], s, 4'h0};
        #0.5;
        v = reg_rdata;
    endtask

    task automatic sample(input int j);
        for (int i = 0; i < 4; i++)
            if (irq[i]) begin
                hits[i]++;
                if (first[i] < 0) first[i] = j;
            end
    endtask

    // n ticking edges; sample j reflects the j-th ticking edge
    task automatic tick_run(input int n);
        for (int i = 0; i < 4; i++) begin hits[i] = 0; first[i] = -1; end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) sample(k);
            tick = 1'b1;
        end
        @(negedge clk);
        sample(n);
        tick = 1'b0;
        @(negedge clk);
        sample(n + 1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R9 irq after reset", {12'h0, irq}, 16'h0);
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++) begin
                rd(t, s[1:0], v);
                chk("R9 register after reset", v, 16'h0);
            end
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(0, MODE, 16'hAB3F); rd(0, MODE, v); chk("R9 mode 8 bits", v, 16'h003F);
        wr(1, CMP, 16'h1234);  rd(1, CMP, v);  chk("R1 compare rw", v, 16'h1234);
        wr(0, HOLD, 16'hBEEF); rd(0, HOLD, v); chk("R7 hold t0", v, 16'hBEEF);
        wr(1, HOLD, 16'h5A5A); rd(1, HOLD, v); chk("R7 hold t1", v, 16'h5A5A);
        wr(2, HOLD, 16'hFFFF); rd(2, HOLD, v); chk("R7 hold t2 zero", v, 16'h0);
        wr(3, HOLD, 16'h7777); rd(3, HOLD, v); chk("R7 hold t3 zero", v, 16'h0);
        rd(0, HOLD, v); chk("R7 hold t0 kept", v, 16'hBEEF);
        reg_addr = 8'b00_10_1111; #0.5;
        chk("R1 low address bits ignored", reg_rdata, 16'h0);
        wr(0, MODE, 16'h0000); wr(1, CMP, 16'h0);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        wr(0, MODE, 16'h0040);
        tick_run(5);
        for (int t = 0; t < 4; t++) begin
            rd(t, CNT, v); chk("R2 disabled no count", v, 16'h0);
        end
        chk("R2 disabled no irq", 16'(hits[0] + hits[1] + hits[2] + hits[3]), 16'h0);
    endtask

    task automatic t_free_run();
        logic [15:0] v;
        wr(0, CNT, 16'h0); wr(0, CMP, 16'd3); wr(0, MODE, 16'h0080);
        tick_run(5);
        chk("R3 one pulse", 16'(hits[0]), 16'd1);
        chk("R3 pulse on third tick", 16'(first[0]), 16'd3);
        rd(0, CNT, v); chk("R5 runs past compare", v, 16'd5);
        rd(0, MODE, v); chk("R6 timer0 stays enabled", v, 16'h0080);
        wr(0, CNT, 16'h0); wr(0, MODE, 16'h00C0);
        tick_run(7);
        chk("R4 zero-return repeats", 16'(hits[0]), 16'd2);
        rd(0, CNT, v); chk("R4 count after reloads", v, 16'd1);
        wr(0, MODE, 16'h0);
    endtask

    task automatic t_one_shot();
        logic [15:0] v;
        wr(2, CNT, 16'h0); wr(2, CMP, 16'd2); wr(2, MODE, 16'h0080);
        wr(1, CNT, 16'h0); wr(1, CMP, 16'd4); wr(1, MODE, 16'h00C0);
        tick_run(8);
        chk("R6 t2 single pulse", 16'(hits[2]), 16'd1);
        chk("R6 t2 pulse at tick 2", 16'(first[2]), 16'd2);
        rd(2, CNT, v);  chk("R6 t2 stopped at compare", v, 16'd2);
        rd(2, MODE, v); chk("R6 t2 enable cleared", v, 16'h0);
        chk("R6 t1 single pulse", 16'(hits[1]), 16'd1);
        rd(1, CNT, v);  chk("R4 t1 zero after match", v, 16'd0);
        rd(1, MODE, v); chk("R6 t1 enable cleared", v, 16'h0040);
    endtask

    task automatic t_wrap();
        logic [15:0] v;
        wr(3, CNT, 16'hFFFE); wr(3, CMP, 16'd5); wr(3, MODE, 16'h0080);
        tick_run(3);
        chk("R5 no irq across wrap", 16'(hits[3]), 16'd0);
        rd(3, CNT, v); chk("R5 wrap to 1", v, 16'd1);
        wr(3, MODE, 16'h0);
    endtask

    task automatic t_sw_write();
        logic [15:0] v;
        wr(0, CNT, 16'h0); wr(0, CMP, 16'h0100); wr(0, MODE, 16'h0080);
        @(negedge clk);
        tick = 1'b1;
        reg_addr = 8'h00; reg_wdata = 16'h0100; reg_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        chk("R8 write raises no irq", {15'h0, irq[0]}, 16'h0);
        rd(0, CNT, v); chk("R8 write beats tick", v, 16'h0100);
        wr(0, MODE, 16'h0);
    endtask

    initial begin
        #(4.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_free_run();
        t_one_shot();
        t_wrap();
        t_sw_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule